// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a set of interrupt sources into one request line and a vector address for a small CPU core. Every source owns a sticky event flag, an enable bit and a level bit. Software reaches these through a four-entry register window, together with a mode bit and two global gates. The CPU answers a raised request with an acknowledge pulse and ends the handler with a return pulse. The block keeps track of which service level is running, so that nesting and re-enabling follow the rules below.

Two modes can be selected at run time. In flat mode every interrupt goes to vector 0x0008. Gate A (bit 7 of the control register) enables all sources, and gate B (bit 6) also gates the peripheral-class sources. In two-level mode gate A enables high-level sources and gate B enables low-level sources. High-level requests go to 0x0008 and low-level requests go to 0x0018. The pin source (index 0) is always high level.

The service tracker is an enumerated state machine with four states:

- SVC_IDLE: no service is running.
- SVC_LOW: a low-level service is running.
- SVC_HIGH: a high-level or flat service is running, entered from idle.
- SVC_NEST: a high-level service is running on top of a low-level one.

Transitions happen only on a taken acknowledge or on a return:

- A high acknowledge moves IDLE to HIGH and LOW to NEST.
- A low acknowledge moves IDLE to LOW.
- A return moves HIGH to IDLE, NEST to LOW and LOW to IDLE.
- A return in IDLE does nothing.
- An acknowledge in the same cycle as a return takes precedence, and that return is dropped.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all flags, enables, gates and the mode bit read 0. The level register reads 0x01, irq_req is 0 and irq_vec is 0x0008. Register addresses: 0 control {bit7 gate A, bit6 gate B, bit0 mode, where 1 means two-level}, 1 flags, 2 enables, 3 levels. Bit i of registers 1 to 3 belongs to source i.
- R2: A pulse on src_evt[i] sets flag i at that clock edge, whatever the enables and gates are. If it coincides with a software write to the flags register, the set wins.
- R3: Flags change only through events or a write to register 1, and a written 0 clears the flag.
- R4: In flat mode, the level bits are ignored. A request needs an enabled set flag and gate A. Sources 4 to 7 also need gate B. The vector is 0x0008. irq_req rises two edges after the event edge at the earliest.
- R5: In two-level mode, an enabled flagged high-level source raises a request with vector 0x0008 when gate A is set.
- R6: In two-level mode, an enabled flagged low-level source raises a request with vector 0x0018 only when gate B and gate A are both set and no service is running.
- R7: An acknowledge while irq_req is high drops irq_req on the next cycle. It clears gate A for a high-level or flat request and gate B for a low-level request.
- R8: A high-level request can be raised and taken during a low-level service. No request is raised while a high-level service runs.
- R9: A return restores the gate cleared at entry of the service being ended. Returning from a nested high service leaves the low service running.
- R10: Once raised, irq_req and irq_vec hold their values until acknowledged, even if software clears the flag in the meantime.
- R11: Level bit 0 always reads 1, and writes to it are ignored.
- R12: A flag still set and enabled after a return raises the request again without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 8 | Event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_ack | input | 1 | CPU takes the pending request |
| irq_ret | input | 1 | CPU returns from the handler |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 16 | Vector for the pending request |

## Verification
The hardest situation to reach is the nested state: a low service in progress, a high service taken on top of it, and a low flag still pending. From that state the unwinding returns must restore exactly one gate each. The stimulus gets there by first taking a low request and leaving its flag set. It then raises and acknowledges a high source, and re-opens the gates by software to show that the state, not the gates, blocks further requests. A behavioural model compares the request, the vector and the rotating register read-back on every cycle while the two returns unwind the stack.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_LOW  = 2'd1,
        SVC_HIGH = 2'd2,
        SVC_NEST = 2'd3
    } svc_e;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_FLAG  = 2'd1;
    localparam logic [1:0] ADR_ENAB  = 2'd2;
    localparam logic [1:0] ADR_LEVEL = 2'd3;

    localparam int CTRL_GATE_A = 7;
    localparam int CTRL_GATE_B = 6;
    localparam int CTRL_MODE   = 0;
endpackage

// File: rtl/icu_src_bank.sv
module icu_src_bank #(
    parameter int NUM_SRC = 8,
    parameter int PIN_SRC = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               wr_flag,
    input  logic               wr_enab,
    input  logic               wr_level,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] flag_o,
    output logic [NUM_SRC-1:0] enab_o,
    output logic [NUM_SRC-1:0] level_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic flag_q;
        logic enab_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                enab_q <= 1'b0;
            end else begin
                flag_q <= (wr_flag ? wdata[i] : flag_q) | src_evt[i];
                if (wr_enab) enab_q <= wdata[i];
            end
        end

        assign flag_o[i] = flag_q;
        assign enab_o[i] = enab_q;

        if (i == PIN_SRC) begin : g_fixed
            assign level_o[i] = 1'b1;
        end else begin : g_prog
            logic level_q;
            always_ff @(posedge clk) begin
                if (!rst_n)        level_q <= 1'b0;
                else if (wr_level) level_q <= wdata[i];
            end
            assign level_o[i] = level_q;
        end
    end

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((flag_o & $past(src_evt)) == $past(src_evt))); // R2
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int FIRST_PERIPH = 4
) (
    input  logic [NUM_SRC-1:0] flag_i,
    input  logic [NUM_SRC-1:0] enab_i,
    input  logic [NUM_SRC-1:0] level_i,
    input  logic               mode_two,
    input  logic               gate_a,
    input  logic               gate_b,
    input  svc_e               svc,
    output logic               cand_hi,
    output logic               cand_lo
);
    logic [NUM_SRC-1:0] periph;
    logic [NUM_SRC-1:0] act;
    logic               hi_busy;
    logic               flat_any;
    logic               two_hi;
    logic               two_lo;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) periph[i] = (i >= FIRST_PERIPH);
    end

    assign act     = flag_i & enab_i;
    assign hi_busy = (svc == SVC_HIGH) || (svc == SVC_NEST);

    assign flat_any = gate_a && ((|(act & ~periph)) || (gate_b && (|(act & periph))));
    assign two_hi   = gate_a && (|(act & level_i));
    assign two_lo   = gate_a && gate_b && (|(act & ~level_i)) && (svc == SVC_IDLE);

    always_comb begin
        if (mode_two) begin
            cand_hi = two_hi && !hi_busy;
            cand_lo = two_lo;
        end else begin
            cand_hi = flat_any && !hi_busy;
            cand_lo = 1'b0;
        end
    end
endmodule

// File: rtl/icu_svc_fsm.sv
module icu_svc_fsm
    import icu_pkg::*;
#(
    parameter int              VEC_W  = 16,
    parameter logic [VEC_W-1:0] VEC_HI = 16'h0008,
    parameter logic [VEC_W-1:0] VEC_LO = 16'h0018
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_hi,
    input  logic             cand_lo,
    input  logic             irq_ack,
    input  logic             irq_ret,
    input  logic             ctrl_we,
    input  logic             wd_gate_a,
    input  logic             wd_gate_b,
    input  logic             wd_mode,
    output logic             gate_a,
    output logic             gate_b,
    output logic             mode_two,
    output svc_e             svc,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);
    svc_e             st_q, st_n;
    logic             pend_q, pend_n;
    logic             phi_q, phi_n;
    logic [VEC_W-1:0] vec_q, vec_n;
    logic             ga_q, ga_n;
    logic             gb_q, gb_n;
    logic             md_q, md_n;
    logic             take;

    assign take = pend_q && irq_ack;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SVC_IDLE;
            pend_q <= 1'b0;
            phi_q  <= 1'b1;
            vec_q  <= VEC_HI;
            ga_q   <= 1'b0;
            gb_q   <= 1'b0;
            md_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            phi_q  <= phi_n;
            vec_q  <= vec_n;
            ga_q   <= ga_n;
            gb_q   <= gb_n;
            md_q   <= md_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        pend_n = pend_q;
        phi_n  = phi_q;
        vec_n  = vec_q;
        ga_n   = ga_q;
        gb_n   = gb_q;
        md_n   = md_q;

        if (ctrl_we) begin
            ga_n = wd_gate_a;
            gb_n = wd_gate_b;
            md_n = wd_mode;
        end

        if (pend_q) begin
            if (irq_ack) pend_n = 1'b0;
        end else if (cand_hi) begin
            pend_n = 1'b1;
            phi_n  = 1'b1;
            vec_n  = VEC_HI;
        end else if (cand_lo) begin
            pend_n = 1'b1;
            phi_n  = 1'b0;
            vec_n  = VEC_LO;
        end

        if (take) begin
            if (phi_q) begin
                ga_n = 1'b0;
                unique case (st_q)
                    SVC_IDLE: st_n = SVC_HIGH;
                    SVC_LOW:  st_n = SVC_NEST;
                    SVC_HIGH: st_n = SVC_HIGH;
                    SVC_NEST: st_n = SVC_NEST;
                endcase
            end else begin
                gb_n = 1'b0;
                if (st_q == SVC_IDLE) st_n = SVC_LOW;
            end
        end else if (irq_ret) begin
            unique case (st_q)
                SVC_HIGH: begin st_n = SVC_IDLE; ga_n = 1'b1; end
                SVC_NEST: begin st_n = SVC_LOW;  ga_n = 1'b1; end
                SVC_LOW:  begin st_n = SVC_IDLE; gb_n = 1'b1; end
                SVC_IDLE: begin st_n = SVC_IDLE; end
            endcase
        end
    end

    assign gate_a   = ga_q;
    assign gate_b   = gb_q;
    assign mode_two = md_q;
    assign svc      = st_q;
    assign irq_req  = pend_q;
    assign irq_vec  = vec_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R10
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req); // R7
    AST_NO_REQ_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc == SVC_HIGH) || (svc == SVC_NEST)) |-> !(irq_req && irq_vec == VEC_LO)); // R8
    AST_FLAT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && !$past(mode_two)) |-> (irq_vec == VEC_HI)); // R4
    AST_RET_HIGH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc == SVC_HIGH && irq_ret && !(irq_req && irq_ack)) |=> (gate_a && svc == SVC_IDLE)); // R9
    AST_RET_NEST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (svc == SVC_NEST && irq_ret && !(irq_req && irq_ack)) |=> (gate_a && svc == SVC_LOW)); // R9
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import icu_pkg::*;
#(
    parameter int NUM_SRC      = 8,
    parameter int FIRST_PERIPH = 4,
    parameter int PIN_SRC      = 0,
    parameter int VEC_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    localparam int REG_W = 8;

    logic [NUM_SRC-1:0] flag_w, enab_w, level_w;
    logic               gate_a, gate_b, mode_two;
    logic               cand_hi, cand_lo;
    svc_e               svc;
    logic               wr_ctrl, wr_flag, wr_enab, wr_level;

    assign wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);
    assign wr_flag  = reg_we && (reg_addr == ADR_FLAG);
    assign wr_enab  = reg_we && (reg_addr == ADR_ENAB);
    assign wr_level = reg_we && (reg_addr == ADR_LEVEL);

    icu_src_bank #(.NUM_SRC(NUM_SRC), .PIN_SRC(PIN_SRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .wr_flag  (wr_flag),
        .wr_enab  (wr_enab),
        .wr_level (wr_level),
        .wdata    (reg_wdata[NUM_SRC-1:0]),
        .flag_o   (flag_w),
        .enab_o   (enab_w),
        .level_o  (level_w)
    );

    icu_arbiter #(.NUM_SRC(NUM_SRC), .FIRST_PERIPH(FIRST_PERIPH)) u_arb (
        .flag_i   (flag_w),
        .enab_i   (enab_w),
        .level_i  (level_w),
        .mode_two (mode_two),
        .gate_a   (gate_a),
        .gate_b   (gate_b),
        .svc      (svc),
        .cand_hi  (cand_hi),
        .cand_lo  (cand_lo)
    );

    icu_svc_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_hi   (cand_hi),
        .cand_lo   (cand_lo),
        .irq_ack   (irq_ack),
        .irq_ret   (irq_ret),
        .ctrl_we   (wr_ctrl),
        .wd_gate_a (reg_wdata[CTRL_GATE_A]),
        .wd_gate_b (reg_wdata[CTRL_GATE_B]),
        .wd_mode   (reg_wdata[CTRL_MODE]),
        .gate_a    (gate_a),
        .gate_b    (gate_b),
        .mode_two  (mode_two),
        .svc       (svc),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTRL_GATE_A] = gate_a;
                reg_rdata[CTRL_GATE_B] = gate_b;
                reg_rdata[CTRL_MODE]   = mode_two;
            end
            ADR_FLAG:  reg_rdata[NUM_SRC-1:0] = flag_w;
            ADR_ENAB:  reg_rdata[NUM_SRC-1:0] = enab_w;
            ADR_LEVEL: reg_rdata[NUM_SRC-1:0] = level_w;
        endcase
    end

    AST_PIN_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_LEVEL) |-> reg_rdata[PIN_SRC]); // R11
    AST_ACK_CLEARS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !reg_we) |=> !(gate_a && gate_b)); // R7
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_evt = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string phase = "R1";
    logic [1:0] rot = '0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // behavioural reference model
    logic [7:0]  m_flag, m_en, m_lvl;
    logic        m_ga, m_gb, m_mode, m_pend, m_phi;
    logic [15:0] m_vec;
    int          m_svc; // 0 idle, 1 low, 2 high, 3 high over low

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0; m_en = 0; m_lvl = 8'h01;
            m_ga = 0; m_gb = 0; m_mode = 0; m_pend = 0; m_phi = 1;
            m_vec = 16'h0008; m_svc = 0;
        end else begin
            logic [7:0] act;
            logic hi_c, lo_c, took;
            act = m_flag & m_en;
            if (m_mode) begin
                hi_c = m_ga && ((act & m_lvl) != 0) && m_svc < 2;
                lo_c = m_ga && m_gb && ((act & ~m_lvl) != 0) && m_svc == 0;
            end else begin
                hi_c = m_ga && (((act & 8'h0F) != 0) || (m_gb && (act & 8'hF0) != 0)) && m_svc < 2;
                lo_c = 0;
            end
            took = m_pend && irq_ack;
            if (reg_we && reg_addr == 0) begin
                m_ga = reg_wdata[7]; m_gb = reg_wdata[6]; m_mode = reg_wdata[0];
            end
            m_flag = ((reg_we && reg_addr == 1) ? reg_wdata : m_flag) | src_evt;
            if (reg_we && reg_addr == 2) m_en = reg_wdata;
            if (reg_we && reg_addr == 3) m_lvl = reg_wdata | 8'h01;
            if (took) begin
                if (m_phi) begin
                    m_ga = 0;
                    if (m_svc == 0) m_svc = 2; else if (m_svc == 1) m_svc = 3;
                end else begin
                    m_gb = 0;
                    if (m_svc == 0) m_svc = 1;
                end
            end else if (irq_ret) begin
                if (m_svc == 2) begin m_svc = 0; m_ga = 1; end
                else if (m_svc == 3) begin m_svc = 1; m_ga = 1; end
                else if (m_svc == 1) begin m_svc = 0; m_gb = 1; end
            end
            if (m_pend) begin
                if (irq_ack) m_pend = 0;
            end else if (hi_c) begin
                m_pend = 1; m_phi = 1; m_vec = 16'h0008;
            end else if (lo_c) begin
                m_pend = 1; m_phi = 0; m_vec = 16'h0018;
            end
        end
    end

    function automatic logic [7:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_ga, m_gb, 5'b0, m_mode};
            2'd1: return m_flag;
            2'd2: return m_en;
            default: return m_lvl;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk({phase, " irq_req"}, {15'b0, irq_req}, {15'b0, m_pend});
            chk({phase, " irq_vec"}, irq_vec, m_vec);
            chk({phase, " reg_rdata"}, {8'b0, reg_rdata}, {8'b0, m_rd(reg_addr)});
        end
    end

    task automatic cyc(input logic [7:0] e, input logic we, input logic [1:0] a,
                       input logic [7:0] d, input logic ak, input logic rt);
        @(posedge clk); #1;
        src_evt = e; reg_we = we; reg_wdata = d; irq_ack = ak; irq_ret = rt;
        reg_addr = we ? a : rot;
        rot = rot + 2'd1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(8'h00, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic ev(input logic [7:0] e);
        cyc(e, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic ret();
        cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic take(input string tag, input logic [15:0] exp_vec);
        for (int k = 0; k < 8 && !irq_req; k++) idle(1);
        chk({tag, " request raised"}, {15'b0, irq_req}, 16'd1);
        chk({tag, " vector"}, irq_vec, exp_vec);
        cyc(8'h00, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        phase = "R1";
        idle(5);
        chk("R1 no request after reset", {15'b0, irq_req}, 16'd0);
        chk("R1 reset vector", irq_vec, 16'h0008);

        phase = "R2";
        ev(8'h05); idle(4);
        cyc(8'h04, 1'b1, 2'd1, 8'h00, 1'b0, 1'b0);   // set beats clear
        idle(4);

        phase = "R3";
        wr(2'd1, 8'h00); idle(4);
        wr(2'd1, 8'h0A); idle(4);
        wr(2'd1, 8'h00); idle(4);

        phase = "R11";
        wr(2'd3, 8'h00); idle(4);
        wr(2'd3, 8'hFE); idle(4);

        phase = "R4";
        wr(2'd3, 8'hFF);                    // levels ignored in flat mode
        wr(2'd2, 8'h11);
        wr(2'd0, 8'h80);
        ev(8'h10); idle(4);
        chk("R4 peripheral blocked by gate B", {15'b0, irq_req}, 16'd0);
        wr(2'd0, 8'hC0);
        take("R4", 16'h0008);
        phase = "R7";
        idle(4);
        wr(2'd1, 8'h00); ret(); idle(4);
        phase = "R4";
        ev(8'h01);
        take("R4 pin", 16'h0008);
        wr(2'd1, 8'h00); ret(); idle(4);

        phase = "R5";
        wr(2'd0, 8'hC1); wr(2'd3, 8'h02); wr(2'd2, 8'h06);
        ev(8'h02);
        take("R5", 16'h0008);
        wr(2'd1, 8'h00); ret(); idle(4);

        phase = "R6";
        wr(2'd0, 8'h41);
        ev(8'h04); idle(4);
        chk("R6 low masked by gate A", {15'b0, irq_req}, 16'd0);
        wr(2'd0, 8'hC1);
        take("R6", 16'h0018);
        idle(3);

        phase = "R8";
        ev(8'h02);
        take("R8 preempt", 16'h0008);
        idle(2);
        wr(2'd0, 8'hC1); idle(5);
        chk("R8 nothing during high service", {15'b0, irq_req}, 16'd0);
        wr(2'd1, 8'h04);

        phase = "R9";
        ret(); idle(4);
        chk("R9 low still in service", {15'b0, irq_req}, 16'd0);
        ret();

        phase = "R12";
        take("R12 re-raise", 16'h0018);
        wr(2'd1, 8'h00); ret(); idle(4);

        phase = "R10";
        ev(8'h02); idle(1);
        wr(2'd1, 8'h00); idle(4);
        chk("R10 request held", {15'b0, irq_req}, 16'd1);
        chk("R10 vector held", irq_vec, 16'h0008);
        take("R10", 16'h0008);
        ret(); idle(6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule